// File: doc/BRIEF.md
# Serial Audio Port Status and Interrupt Register Bank

This block holds the status word and the interrupt mask of a serial audio port. It sits on a simple 32-bit register bus with byte addresses and a 4-byte stride. Reads are combinational, and writes take effect at the clock edge. The receive and transmit datapaths feed it in two ways. Four level inputs report whether each direction is enabled and ready. Two event pulses report a receive overrun and a transmit underrun, and each pulse carries the index of the time-slot channel it hit.

Each overrun or underrun sets a sticky summary flag. It also sets a sticky flag for the channel it hit, for up to eight time-slot channels. Software clears sticky bits by writing ones to a clear register and can force them with a set register. It opens and closes interrupt sources through separate enable and disable registers, and their combined result is read back from a mask register. One level interrupt output is high while any masked status bit is set.

Top module: `audio_stat_irq`

## Requirements
- R1: Status (offset 0x08) shows the receiver-on level at bit 0, receiver-ready at bit 1, transmitter-on at bit 4 and transmitter-ready at bit 5. These bits follow the inputs in the same cycle.
- R2: An overrun pulse sets summary bit 2 and the per-channel bit 8+n. The channel n is the slot input modulo 8, so slot 11 sets bit 11.
- R3: An underrun pulse sets summary bit 6 and the per-channel bit 20+n, with n the slot input modulo 8.
- R4: Bits 2, 6, 15:8 and 27:20 are sticky. They stay set after the pulse ends, until software clears them.
- R5: Writing a word to the clear register (0x0C) clears each sticky bit whose position holds a 1. Positions that hold 0 keep their value.
- R6: Writing a word to the set register (0x10) sets each sticky bit whose position holds a 1. Neither the set register nor the clear register changes bits 0, 1, 4 or 5.
- R7: A 1 written to the enable register (0x14) sets the matching mask bit, and a 1 written to the disable register (0x18) clears it. Zeros leave the mask alone. Only bits 1, 2, 5 and 6 can be set, and the mask reads at 0x1C.
- R8: `irq` is high exactly when the status word AND the mask is nonzero.
- R9: If a hardware event and a clear of the same bit land in one cycle, the bit stays set.
- R10: Reads of 0x0C, 0x10, 0x14 and 0x18 return zero. Writes to 0x08 and 0x1C change nothing.
- R11: After reset all sticky flags and the mask are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rx_on | input | 1 | Receiver enabled level |
| rx_ready | input | 1 | Receive data ready level |
| tx_on | input | 1 | Transmitter enabled level |
| tx_ready | input | 1 | Transmit holding ready level |
| rx_ovr_ev | input | 1 | Receive overrun pulse |
| rx_ovr_slot | input | SLOT_SEL_W | Channel of the overrun |
| tx_und_ev | input | 1 | Transmit underrun pulse |
| tx_und_slot | input | SLOT_SEL_W | Channel of the underrun |
| irq | output | 1 | Level interrupt |

## Verification
The collision that matters is a datapath overrun pulse arriving in the same clock cycle as a software write to the clear register that names the same summary bit and channel bit. The bench drives the pulse and the clear write on the same falling edge and removes both on the next. It then reads the status word, which must still show both bits. A later clear with no event present must remove them.

// File: rtl/aud_stat_pkg.sv
`timescale 1ns/1ps
package aud_stat_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned MAX_SLOTS = 8;
    localparam int unsigned IDX_W     = $clog2(MAX_SLOTS);

    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_CLR  = 8'h0C;
    localparam logic [7:0] OFS_SET  = 8'h10;
    localparam logic [7:0] OFS_IEN  = 8'h14;
    localparam logic [7:0] OFS_IDIS = 8'h18;
    localparam logic [7:0] OFS_MASK = 8'h1C;

    localparam int unsigned B_RXON   = 0;
    localparam int unsigned B_RXRDY  = 1;
    localparam int unsigned B_RXOVR  = 2;
    localparam int unsigned B_TXON   = 4;
    localparam int unsigned B_TXRDY  = 5;
    localparam int unsigned B_TXUND  = 6;
    localparam int unsigned RXSLOT_LSB = 8;
    localparam int unsigned TXSLOT_LSB = 20;

    localparam logic [REG_W-1:0] IRQ_CAPABLE =
        (REG_W'(1) << B_RXRDY) | (REG_W'(1) << B_RXOVR) |
        (REG_W'(1) << B_TXRDY) | (REG_W'(1) << B_TXUND);

    typedef struct packed {
        logic clr;
        logic set;
        logic ien;
        logic idis;
    } wr_strobe_t;

    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_STAT = 2'd1,
        RD_MASK = 2'd2
    } rd_sel_t;

    typedef struct packed {
        logic rx_on;
        logic rx_rdy;
        logic tx_on;
        logic tx_rdy;
    } levels_t;

    typedef struct packed {
        logic                 rx_ovr;
        logic [MAX_SLOTS-1:0] rx_slot;
        logic                 tx_und;
        logic [MAX_SLOTS-1:0] tx_slot;
    } sticky_t;

    function automatic logic [REG_W-1:0] pack_status(levels_t lv, sticky_t st);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_RXON]  = lv.rx_on;
        w[B_RXRDY] = lv.rx_rdy;
        w[B_TXON]  = lv.tx_on;
        w[B_TXRDY] = lv.tx_rdy;
        w[B_RXOVR] = st.rx_ovr;
        w[B_TXUND] = st.tx_und;
        w[RXSLOT_LSB +: MAX_SLOTS] = st.rx_slot;
        w[TXSLOT_LSB +: MAX_SLOTS] = st.tx_slot;
        return w;
    endfunction

    function automatic sticky_t unpack_sticky(logic [REG_W-1:0] w);
        sticky_t s;
        s.rx_ovr  = w[B_RXOVR];
        s.tx_und  = w[B_TXUND];
        s.rx_slot = w[RXSLOT_LSB +: MAX_SLOTS];
        s.tx_slot = w[TXSLOT_LSB +: MAX_SLOTS];
        return s;
    endfunction

endpackage

// File: rtl/aud_reg_decode.sv
`timescale 1ns/1ps
module aud_reg_decode
    import aud_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        stb,
    output rd_sel_t           sel
);

    always_comb begin
        stb      = '0;
        stb.clr  = wr && (addr == ADDR_W'(OFS_CLR));
        stb.set  = wr && (addr == ADDR_W'(OFS_SET));
        stb.ien  = wr && (addr == ADDR_W'(OFS_IEN));
        stb.idis = wr && (addr == ADDR_W'(OFS_IDIS));
    end

    always_comb begin
        if (addr == ADDR_W'(OFS_STAT))
            sel = RD_STAT;
        else if (addr == ADDR_W'(OFS_MASK))
            sel = RD_MASK;
        else
            sel = RD_ZERO;
    end

endmodule

// File: rtl/aud_flag_bit.sv
`timescale 1ns/1ps
module aud_flag_bit (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic set_req,
    input  logic clr_req,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= hit | set_req | (q & ~clr_req);
    end

    // R9
    flag_event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> q);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (q && !clr_req) |=> q);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit && !set_req) |=> !q);

endmodule

// File: rtl/aud_sticky_bank.sv
`timescale 1ns/1ps
module aud_sticky_bank
    import aud_stat_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 8,
    parameter int unsigned SLOT_SEL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_ovr_ev,
    input  logic [SLOT_SEL_W-1:0] rx_ovr_slot,
    input  logic                  tx_und_ev,
    input  logic [SLOT_SEL_W-1:0] tx_und_slot,
    input  logic                  clr_wr,
    input  logic                  set_wr,
    input  sticky_t               wsel,
    output sticky_t               st
);

    logic [IDX_W-1:0]     rx_idx, tx_idx;
    logic [MAX_SLOTS-1:0] rx_q, tx_q;
    logic                 rx_sum_q, tx_sum_q;

    assign rx_idx = IDX_W'(rx_ovr_slot % SLOT_SEL_W'(MAX_SLOTS));
    assign tx_idx = IDX_W'(tx_und_slot % SLOT_SEL_W'(MAX_SLOTS));

    aud_flag_bit u_rx_sum (
        .clk(clk), .rst(rst), .hit(rx_ovr_ev),
        .set_req(set_wr && wsel.rx_ovr), .clr_req(clr_wr && wsel.rx_ovr),
        .q(rx_sum_q)
    );

    aud_flag_bit u_tx_sum (
        .clk(clk), .rst(rst), .hit(tx_und_ev),
        .set_req(set_wr && wsel.tx_und), .clr_req(clr_wr && wsel.tx_und),
        .q(tx_sum_q)
    );

    for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
        if (s < NUM_SLOTS) begin : g_live
            aud_flag_bit u_rx (
                .clk(clk), .rst(rst),
                .hit(rx_ovr_ev && (rx_idx == IDX_W'(s))),
                .set_req(set_wr && wsel.rx_slot[s]),
                .clr_req(clr_wr && wsel.rx_slot[s]),
                .q(rx_q[s])
            );
            aud_flag_bit u_tx (
                .clk(clk), .rst(rst),
                .hit(tx_und_ev && (tx_idx == IDX_W'(s))),
                .set_req(set_wr && wsel.tx_slot[s]),
                .clr_req(clr_wr && wsel.tx_slot[s]),
                .q(tx_q[s])
            );
        end else begin : g_tied
            assign rx_q[s] = 1'b0;
            assign tx_q[s] = 1'b0;
        end
    end

    always_comb begin
        st.rx_ovr  = rx_sum_q;
        st.rx_slot = rx_q;
        st.tx_und  = tx_sum_q;
        st.tx_slot = tx_q;
    end

    // R2
    rx_slot_mark_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ovr_ev |=> (rx_sum_q && (32'($past(rx_idx)) >= NUM_SLOTS || rx_q[$past(rx_idx)])));

    // R3
    tx_slot_mark_chk: assert property (@(posedge clk) disable iff (rst)
        tx_und_ev |=> (tx_sum_q && (32'($past(tx_idx)) >= NUM_SLOTS || tx_q[$past(tx_idx)])));

endmodule

// File: rtl/aud_irq_mask.sv
`timescale 1ns/1ps
module aud_irq_mask
    import aud_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q
);

    logic [REG_W-1:0] pick;
    assign pick = wdata & IRQ_CAPABLE;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (ien_wr)
            mask_q <= mask_q | pick;
        else if (idis_wr)
            mask_q <= mask_q & ~pick;
    end

    // R7
    mask_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ien_wr |=> ((mask_q & $past(pick)) == $past(pick)));

    // R7
    mask_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (idis_wr && !ien_wr) |=> ((mask_q & $past(wdata)) == '0));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ien_wr && !idis_wr) |=> $stable(mask_q));

    // R11
    mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0));

endmodule

// File: rtl/audio_stat_irq.sv
`timescale 1ns/1ps
module audio_stat_irq
    import aud_stat_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_SLOTS  = 8,
    parameter int unsigned SLOT_SEL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic                  rx_on,
    input  logic                  rx_ready,
    input  logic                  tx_on,
    input  logic                  tx_ready,
    input  logic                  rx_ovr_ev,
    input  logic [SLOT_SEL_W-1:0] rx_ovr_slot,
    input  logic                  tx_und_ev,
    input  logic [SLOT_SEL_W-1:0] tx_und_slot,
    output logic                  irq
);

    wr_strobe_t       stb;
    rd_sel_t          sel;
    sticky_t          st;
    sticky_t          wsel;
    levels_t          lv;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] status_w;

    aud_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr(bus_wr), .addr(bus_addr), .stb(stb), .sel(sel)
    );

    assign wsel = unpack_sticky(bus_wdata);

    aud_sticky_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_SEL_W(SLOT_SEL_W)) u_bank (
        .clk(clk), .rst(rst),
        .rx_ovr_ev(rx_ovr_ev), .rx_ovr_slot(rx_ovr_slot),
        .tx_und_ev(tx_und_ev), .tx_und_slot(tx_und_slot),
        .clr_wr(stb.clr), .set_wr(stb.set), .wsel(wsel), .st(st)
    );

    aud_irq_mask u_mask (
        .clk(clk), .rst(rst), .ien_wr(stb.ien), .idis_wr(stb.idis),
        .wdata(bus_wdata), .mask_q(mask_q)
    );

    always_comb begin
        lv.rx_on  = rx_on;
        lv.rx_rdy = rx_ready;
        lv.tx_on  = tx_on;
        lv.tx_rdy = tx_ready;
    end

    assign status_w = pack_status(lv, st);
    assign irq      = |(status_w & mask_q);

    always_comb begin
        unique case (sel)
            RD_STAT: bus_rdata = status_w;
            RD_MASK: bus_rdata = mask_q;
            default: bus_rdata = '0;
        endcase
    end

    // R10
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && !rx_ovr_ev && !tx_und_ev) |=> $stable(st));

    // R10
    mask_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> $stable(mask_q));

endmodule

// File: tb/sim_audio_stat_irq.sv
`timescale 1ns/1ps
module sim_audio_stat_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_on = 1'b0, rx_ready = 1'b0, tx_on = 1'b0, tx_ready = 1'b0;
    logic        rx_ovr_ev = 1'b0, tx_und_ev = 1'b0;
    logic [3:0]  rx_ovr_slot = '0, tx_und_slot = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    audio_stat_irq u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_on(rx_on), .rx_ready(rx_ready), .tx_on(tx_on), .tx_ready(tx_ready),
        .rx_ovr_ev(rx_ovr_ev), .rx_ovr_slot(rx_ovr_slot),
        .tx_und_ev(tx_und_ev), .tx_und_slot(tx_und_slot), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ovr(input logic [3:0] s);
        @(negedge clk);
        rx_ovr_ev = 1'b1; rx_ovr_slot = s;
        @(negedge clk);
        rx_ovr_ev = 1'b0;
    endtask

    task automatic und(input logic [3:0] s);
        @(negedge clk);
        tx_und_ev = 1'b1; tx_und_slot = s;
        @(negedge clk);
        tx_und_ev = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h08, d); chk("R11 status after reset", d, 32'h0);
        rd(8'h1C, d); chk("R11 mask after reset", d, 32'h0);
        chk("R11 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        @(negedge clk); rx_on = 1'b1; tx_ready = 1'b1;
        rd(8'h08, d); chk("R1 level bits", d, 32'h0000_0021);
        @(negedge clk); rx_on = 1'b0; rx_ready = 1'b1; tx_on = 1'b1; tx_ready = 1'b0;
        rd(8'h08, d); chk("R1 level bits swap", d, 32'h0000_0012);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R6 clear leaves levels", d, 32'h0000_0012);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R6 set all sticky", d, 32'h0FF0_FF56);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R5 clear all sticky", d, 32'h0000_0012);
        @(negedge clk); rx_ready = 1'b0; tx_on = 1'b0;
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        ovr(4'd5);
        rd(8'h08, d); chk("R2 overrun ch5", d, 32'h0000_2004);
        ovr(4'd11);
        repeat (4) @(negedge clk);
        rd(8'h08, d); chk("R2 R4 slot 11 maps to ch3, sticky", d, 32'h0000_2804);
        wr(8'h0C, 32'h0000_2004);
        rd(8'h08, d); chk("R5 partial clear keeps ch3", d, 32'h0000_0800);
        wr(8'h0C, 32'h0000_0800);
    endtask

    task automatic t_underrun();
        logic [31:0] d;
        und(4'd0);
        und(4'd15);
        rd(8'h08, d); chk("R3 underrun ch0 and ch7", d, 32'h0810_0040);
        wr(8'h0C, 32'h0800_0000);
        rd(8'h08, d); chk("R5 clear ch7 only", d, 32'h0010_0040);
        wr(8'h0C, 32'h0010_0040);
        rd(8'h08, d); chk("R5 underrun cleared", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R7 enable limited to 1,2,5,6", d, 32'h0000_0066);
        wr(8'h18, 32'h0000_0004);
        rd(8'h1C, d); chk("R7 disable bit2", d, 32'h0000_0062);
        wr(8'h14, 32'h0);
        rd(8'h1C, d); chk("R7 zero enable no change", d, 32'h0000_0062);
        wr(8'h18, 32'h0);
        rd(8'h1C, d); chk("R7 zero disable no change", d, 32'h0000_0062);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R7 disable all", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h14, 32'h0000_0004);
        @(negedge clk); rx_ready = 1'b1;
        #1 chk("R8 unmasked ready no irq", {31'b0, irq}, 32'h0);
        wr(8'h14, 32'h0000_0002);
        #1 chk("R8 ready enabled irq", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h0000_0002);
        #1 chk("R8 ready disabled irq low", {31'b0, irq}, 32'h0);
        ovr(4'd2);
        #1 chk("R8 overrun irq", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0000_0404);
        #1 chk("R8 cleared irq low", {31'b0, irq}, 32'h0);
        @(negedge clk); rx_ready = 1'b0;
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R8 status idle", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk);
        rx_ovr_ev = 1'b1; rx_ovr_slot = 4'd3;
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0804;
        @(negedge clk);
        rx_ovr_ev = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(8'h08, d); chk("R9 event beats clear", d, 32'h0000_0804);
        wr(8'h0C, 32'h0000_0804);
        rd(8'h08, d); chk("R9 later clear works", d, 32'h0);
    endtask

    task automatic t_writeonly();
        logic [31:0] d;
        wr(8'h14, 32'h0000_0020);
        ovr(4'd1);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R10 status write ignored", d, 32'h0000_0204);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R10 mask write ignored", d, 32'h0000_0020);
        rd(8'h0C, d); chk("R10 clear reads zero", d, 32'h0);
        rd(8'h10, d); chk("R10 set reads zero", d, 32'h0);
        rd(8'h14, d); chk("R10 enable reads zero", d, 32'h0);
        rd(8'h18, d); chk("R10 disable reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_levels();
        t_overrun();
        t_underrun();
        t_mask();
        t_irq();
        t_collision();
        t_writeonly();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got=%08h exp=%08h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule